// File: doc/BRIEF.md
# Bitsliced Substitution-Permutation Round Engine

This block encrypts one 128-bit block by iterating a substitution-permutation round. It performs one round per clock. The state is held as four 32-bit words. Each round XORs a 128-bit round key onto the state. It then passes all 32 bit-slices through a 4-bit S-box, where a slice is the same bit position in each of the four words. Finally it mixes the words with a fixed rotate/shift/XOR network. Eight S-boxes are used in turn, chosen by the round number modulo 8.

The block does not expand keys. It presents a key index on `round_idx_o`, and the surrounding logic must drive the matching 128-bit round key on `rk_i` in the same cycle. That path is combinational from the index. Thirty-three round keys are consumed: index 0 is mixed in when the block is loaded, and index r+1 is mixed in at the end of round r. The last round skips the mixing network. The result is presented on `ct_o` together with a one-cycle `done_o` pulse, 32 clocks after the start edge.

Top module: `spn_round_engine`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, `round_idx_o` is 0 and `ct_o` is all zeros.
- R2: While idle `round_idx_o` is 0. When `start_i` is sampled high while idle, the engine loads `pt_i ^ rk_i` (key 0). During round r (r = 0..31) `round_idx_o` equals r+1. A start in the same cycle as `done_o` is accepted.
- R3: `done_o` rises exactly 32 rising edges after the edge that accepted the start, lasts one cycle, and `busy_o` falls with it.
- R4: `start_i` has no effect while `busy_o` is high: the round count, the result and the done timing are unchanged.
- R5: S-box tables, for input values 0..15. S0: 3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12. S1: 15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4. S2: 8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2. S3: 0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14. S4: 1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13. S5: 15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1. S6: 7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0. S7: 1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6. Slice j takes bit j of word k as nibble bit k, with word 0 as the LSB. The output nibble is written back the same way. Word k occupies bits [32k+31:32k] of each 128-bit port.
- R6: Round r substitutes with S-box number r mod 8.
- R7: Every round except the last applies, after substitution, the following network, where rl is rotate-left and << is a logical shift that drops bits. First a=rl(x0,13) and c=rl(x2,3). Then b=rl(x1^a^c,1) and d=rl(x3^c^(a<<3),7). The outputs are y0=rl(a^b^d,5), y1=b, y2=rl(c^d^(b<<7),22) and y3=d.
- R8: Round 31 skips the network and XORs key 32 onto the S-box output.
- R9: `ct_o` holds the result unchanged from `done_o` until the next accepted start.
- R10: Key mixing XORs word k of the round key onto state word k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin encrypting `pt_i` (ignored while busy) |
| pt_i | input | 128 | Plaintext block, four words |
| rk_i | input | 128 | Round key for index `round_idx_o` |
| round_idx_o | output | 6 | Index of the round key wanted this cycle |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| ct_o | output | 128 | Ciphertext, valid from `done_o` until the next start |

## Verification
All eight S-boxes are driven through the substitution layer on their own. Each pass feeds all sixteen nibble values across the slices, which catches a swapped table, a wrong table entry or a word-to-bit order that is reversed. Whole blocks are compared against an arithmetic model in the bench. That comparison exposes three kinds of fault: a rotate in place of a logical shift in the mixing network, mixing applied or key 32 dropped in the last round, and an S-box rotation that is off by one round. Key-index sequencing and the exact done cycle are checked on every block. A start raised mid-run must leave the result intact, which catches a design that restarts or corrupts the state. Results must also hold after done, and a start issued in the done cycle must be accepted.

// File: rtl/spn_pkg.sv
package spn_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int BLK_W     = WORD_W * NUM_WORDS;
  localparam int NUM_SBOX  = 8;
  localparam int SEL_W     = $clog2(NUM_SBOX);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NUM_WORDS-1:0][WORD_W-1:0] blk_t;

  // entry i of each table at bits [4i+3:4i]
  function automatic logic [3:0] sbox_lut(input logic [SEL_W-1:0] sel, input logic [3:0] n);
    logic [63:0] t;
    case (sel)
      3'd0:    t = 64'hC90724DEB56A1F83;
      3'd1:    t = 64'h43D68EB1A50972CF;
      3'd2:    t = 64'h25B04E1DFAC39768;
      3'd3:    t = 64'hE57A421D369C8BF0;
      3'd4:    t = 64'hD7E9A4526B0C38F1;
      3'd5:    t = 64'h176D8E30C9A4B25F;
      3'd6:    t = 64'h0A3DF19EB6485C27;
      default: t = 64'h6539AC47B28E0FD1;
    endcase
    return t[{n, 2'b00} +: 4];
  endfunction

  function automatic word_t rol(input word_t v, input int unsigned n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction
endpackage

// File: rtl/spn_sbox_layer.sv
module spn_sbox_layer
  import spn_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  blk_t             x_i,
  output blk_t             y_o
);
  logic [NUM_WORDS-1:0] slc [WORD_W];

  for (genvar j = 0; j < WORD_W; j++) begin : g_slice
    logic [NUM_WORDS-1:0] nib;
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_gather
      assign nib[k] = x_i[k][j];
    end
    assign slc[j] = sbox_lut(sel_i, nib);
  end

  always_comb begin
    for (int j = 0; j < WORD_W; j++) begin
      for (int k = 0; k < NUM_WORDS; k++) begin
        y_o[k][j] = slc[j][k];
      end
    end
  end
endmodule

// File: rtl/spn_lin_mix.sv
module spn_lin_mix
  import spn_pkg::*;
#(
  parameter int unsigned ROT_A = 13,
  parameter int unsigned ROT_C = 3,
  parameter int unsigned SHL_A = 3,
  parameter int unsigned ROT_B = 1,
  parameter int unsigned ROT_D = 7,
  parameter int unsigned SHL_B = 7,
  parameter int unsigned ROT_Y0 = 5,
  parameter int unsigned ROT_Y2 = 22
) (
  input  blk_t x_i,
  output blk_t y_o
);
  word_t a, b, c, d;

  always_comb begin
    a = rol(x_i[0], ROT_A);
    c = rol(x_i[2], ROT_C);
    // logical shifts: bits leaving the word are dropped
    b = rol(x_i[1] ^ a ^ c, ROT_B);
    d = rol(x_i[3] ^ c ^ (a << SHL_A), ROT_D);
    y_o[0] = rol(a ^ b ^ d, ROT_Y0);
    y_o[1] = b;
    y_o[2] = rol(c ^ d ^ (b << SHL_B), ROT_Y2);
    y_o[3] = d;
  end
endmodule

// File: rtl/spn_round_ctrl.sv
module spn_round_ctrl #(
  parameter int ROUNDS = 32,
  localparam int CNT_W = $clog2(ROUNDS),
  localparam int IDX_W = $clog2(ROUNDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             last_o,
  output logic [CNT_W-1:0] rnd_o,
  output logic [IDX_W-1:0] key_idx_o
);
  logic             busy_q, done_q;
  logic [CNT_W-1:0] rnd_q;

  assign load_o    = start_i && !busy_q;
  assign last_o    = (rnd_q == CNT_W'(ROUNDS - 1));
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rnd_o     = rnd_q;
  assign key_idx_o = busy_q ? IDX_W'(rnd_q) + IDX_W'(1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        busy_q <= 1'b1;
        rnd_q  <= '0;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          rnd_q <= rnd_q + CNT_W'(1);
        end
      end
    end
  end

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> (busy_q && rnd_q == $past(rnd_q) + CNT_W'(1)));
  p_finish_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last_o) |=> (done_q && !busy_q));
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_idx_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (key_idx_o == '0));
endmodule

// File: rtl/spn_round_engine.sv
module spn_round_engine
  import spn_pkg::*;
#(
  parameter int ROUNDS = 32,
  localparam int CNT_W = $clog2(ROUNDS),
  localparam int IDX_W = $clog2(ROUNDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] pt_i,
  input  logic [BLK_W-1:0] rk_i,
  output logic [IDX_W-1:0] round_idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [BLK_W-1:0] ct_o
);
  logic             load, last;
  logic [CNT_W-1:0] rnd;
  blk_t             state_q, sb_out, mx_out, nxt;

  spn_round_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .load_o    (load),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .last_o    (last),
    .rnd_o     (rnd),
    .key_idx_o (round_idx_o)
  );

  spn_sbox_layer u_sbox (
    .sel_i (SEL_W'(rnd % CNT_W'(NUM_SBOX))),
    .x_i   (state_q),
    .y_o   (sb_out)
  );

  spn_lin_mix u_mix (
    .x_i (sb_out),
    .y_o (mx_out)
  );

  // state carries the key-mixed value; final round bypasses the mix
  assign nxt = (last ? sb_out : mx_out) ^ blk_t'(rk_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (load)   state_q <= blk_t'(pt_i) ^ blk_t'(rk_i);
    else if (busy_o) state_q <= nxt;
  end

  assign ct_o = state_q;

  p_ct_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(state_q));
endmodule

// File: tb/spn_round_engine_bench.sv
`timescale 1ns/1ps
module spn_round_engine_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] pt = '0;
  logic [127:0] rk;
  logic [5:0]   round_idx;
  logic         busy, done;
  logic [127:0] ct;

  logic [127:0] keys [33];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always_comb rk = (round_idx <= 6'd32) ? keys[round_idx] : '0;

  spn_round_engine u_spn_round_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pt_i(pt), .rk_i(rk),
    .round_idx_o(round_idx), .busy_o(busy), .done_o(done), .ct_o(ct)
  );

  logic [2:0]   probe_sel;
  logic [127:0] probe_x, probe_y;
  spn_sbox_layer u_probe (.sel_i(probe_sel), .x_i(probe_x), .y_o(probe_y));

  int t0[16] = '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12};
  int t1[16] = '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4};
  int t2[16] = '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2};
  int t3[16] = '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14};
  int t4[16] = '{1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13};
  int t5[16] = '{15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1};
  int t6[16] = '{7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0};
  int t7[16] = '{1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6};

  function automatic int sb(int s, int n);
    case (s)
      0: return t0[n]; 1: return t1[n]; 2: return t2[n]; 3: return t3[n];
      4: return t4[n]; 5: return t5[n]; 6: return t6[n]; default: return t7[n];
    endcase
  endfunction

  function automatic logic [31:0] rl(logic [31:0] v, int n);
    logic [63:0] d = {v, v} >> (32 - n);
    return d[31:0];
  endfunction

  function automatic logic [127:0] subst(logic [127:0] s, int box);
    logic [127:0] o = '0;
    for (int j = 0; j < 32; j++) begin
      int n = 0;
      for (int k = 0; k < 4; k++) n += int'(s[32*k + j]) << k;
      n = sb(box, n);
      for (int k = 0; k < 4; k++) o[32*k + j] = n[k];
    end
    return o;
  endfunction

  function automatic logic [127:0] mix(logic [127:0] s);
    logic [31:0] a, b, c, d;
    a = rl(s[31:0], 13);
    c = rl(s[95:64], 3);
    b = rl(s[63:32] ^ a ^ c, 1);
    d = rl(s[127:96] ^ c ^ (a << 3), 7);
    return {d, rl(c ^ d ^ (b << 7), 22), b, rl(a ^ b ^ d, 5)};
  endfunction

  function automatic logic [127:0] model(logic [127:0] p);
    logic [127:0] s = p ^ keys[0];
    for (int r = 0; r < 32; r++) begin
      s = subst(s, r % 8);
      if (r < 31) s = mix(s);
      s = s ^ keys[r + 1];
    end
    return s;
  endfunction

  task automatic set_keys(int seed);
    for (int i = 0; i < 33; i++)
      for (int w = 0; w < 4; w++)
        keys[i][32*w +: 32] = 32'(seed) * 32'h9E3779B9 + 32'(i) * 32'h7F4A7C15
                              + 32'(w) * 32'h01234567 ^ (32'(seed) << (i % 17));
  endtask

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_block(input logic [127:0] p, output logic [127:0] res);
    int idx_bad = 0;
    int done_at = -1;
    @(negedge clk);
    start = 1'b1;
    pt = p;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 1; i <= 32; i++) begin
      if (round_idx != 6'(i)) idx_bad++;
      @(posedge clk); #1;
      if (done && done_at < 0) done_at = i;
    end
    chk(idx_bad == 0, "R2 key index sequence", 128'(idx_bad), 128'd0);
    chk(done_at == 32 && !busy, "R3 done cycle", 128'(done_at), 128'd32);
    res = ct;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] r, e, held;
    set_keys(0);
    probe_sel = '0;
    probe_x = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
    chk(round_idx == 0, "R1 index", round_idx, 0);
    chk(ct == '0, "R1 ct", ct, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R5 R6: every S-box, all 16 inputs spread over the slices
    for (int s = 0; s < 8; s++) begin
      logic [127:0] ex = '0;
      probe_sel = 3'(s);
      for (int j = 0; j < 32; j++)
        for (int k = 0; k < 4; k++) begin
          int n = j % 16;
          probe_x[32*k + j] = n[k];
          ex[32*k + j] = 1'(sb(s, n) >> k);
        end
      #1;
      chk(probe_y == ex, $sformatf("R5 sbox %0d", s), probe_y, ex);
    end

    // R7 R8 R10: whole blocks, zero keys and pattern keys
    run_block('0, r);
    e = model('0);
    chk(r == e, "R8 zero block zero keys", r, e);
    for (int t = 1; t <= 6; t++) begin
      logic [127:0] p = {32'(t) * 32'hA5A5_0F0F, 32'hFFFF_FFFF >> t,
                         32'(t) << 28, 32'h8000_0001 ^ 32'(t)};
      set_keys(t);
      run_block(p, r);
      e = model(p);
      chk(r == e, $sformatf("R7 R10 block %0d", t), r, e);
    end

    // R9: result held while idle
    held = ct;
    repeat (7) @(posedge clk);
    #1;
    chk(ct == held && !done, "R9 hold", ct, held);

    // R4: start pulses during a run are ignored
    set_keys(9);
    begin
      logic [127:0] p = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
      int done_at = -1;
      @(negedge clk);
      start = 1'b1;
      pt = p;
      @(posedge clk); #1;
      start = 1'b0;
      for (int i = 1; i <= 32; i++) begin
        if (i >= 5 && i <= 8) begin
          start = 1'b1;
          pt = ~p;
        end else start = 1'b0;
        @(posedge clk); #1;
        if (done && done_at < 0) done_at = i;
      end
      start = 1'b0;
      chk(done_at == 32, "R4 done timing under start", 128'(done_at), 128'd32);
      e = model(p);
      chk(ct == e, "R4 result under start", ct, e);
    end

    // R2: start accepted in the done cycle
    set_keys(11);
    run_block(128'hDEAD_BEEF_0000_0000_1111_2222_3333_4444, r);
    run_block(128'h5555_AAAA_5555_AAAA_0F0F_F0F0_00FF_FF00, r);
    e = model(128'h5555_AAAA_5555_AAAA_0F0F_F0F0_00FF_FF00);
    chk(r == e, "R2 back-to-back start", r, e);
    @(posedge clk); #1;
    chk(!done && round_idx == 0, "R3 single pulse", {done, round_idx}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule